// File: doc/BRIEF.md
# Round-robin event collector

This block gathers events from ten per-channel event buffers and merges them into one collected event stream. A scan pointer walks the channels in ascending order. A channel that has no complete event waiting costs one cycle and is passed over. A channel that has one gives up exactly one whole event, word after word, before the pointer moves on. No channel is preferred, so a channel with a deep backlog still gets only one event per lap.

Every event is a run of 16-bit words and begins with a 28-word header. Each channel reports that an event is ready and gives its length in words. It then shows the current word and advances when the block pops it. While the event is copied, the block writes the channel number into a reserved nibble of the header, and it also outputs the channel number beside every word. The collected FIFO reports its free space in words. The block starts an event only when the whole event fits, and until then it waits on that channel.

Top module: `evt_rr_collector`

## Requirements
- R1: While reset is asserted and right after it, no channel is popped and nothing is written, and the scan starts at channel 0.
- R2: Channels are visited in the order 0, 1, … 9, and after channel 9 the scan returns to channel 0.
- R3: Each visit to a channel with a ready event moves exactly one event, whatever that channel's backlog is.
- R4: A channel with no ready event uses one cycle of scan time. When only channel 9 holds an event after reset, its first word is written on the 10th rising edge after reset is released.
- R5: An event of length L is moved in L consecutive cycles. Each of those cycles pops one word from the visited channel and writes one word, and no other channel is served in between.
- R6: If the free-space count is below the current event's length, the block waits on that channel without writing and without moving to the next channel. It starts the event once the space is there.
- R7: At header word index 1 (counting from 0), bits [3:0] of the written word carry the channel number. Every other bit and every other word passes through unchanged.
- R8: On every write, the channel-tag output equals the channel that the word came from.
- R9: Event lengths presented with the ready flag are at least the 28-word header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_avail | input | 10 | Per channel: a complete event is ready |
| ch_len | input | 120 | Per channel: 12-bit length of the ready event in words (channel c at bits 12c+11:12c) |
| ch_word | input | 160 | Per channel: 16-bit current word (channel c at bits 16c+15:16c) |
| ch_pop | output | 10 | Per channel: take the current word this cycle |
| cf_room | input | 12 | Free words in the collected FIFO |
| cf_wr | output | 1 | Write strobe into the collected FIFO |
| cf_data | output | 16 | Word written, with the channel tag inserted |
| cf_chan | output | 4 | Channel of the word written |

## Verification
The bench gives every channel two events of different lengths. The merged stream must then interleave the channels one event per lap, and it must wrap after channel 9. A block that drained one channel before moving on, or that never wrapped, would produce a different order. A lopsided load, with one channel holding three events, checks that the busy channel waits a full lap between its events. A timing case places a single event on channel 9 and counts edges from reset to its first word, which would catch a block that spends more or less than one cycle on each empty channel. A stall case offers too little space for channel 2's event but enough for channel 3's. A block that skipped the stalled channel, or that started writing early, would emit channel 3 first.

// File: rtl/ec_pkg.sv
package ec_pkg;

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_XFER = 1'b1
    } ec_state_e;

    function automatic int next_chan(int cur, int n);
        return (cur == n - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/ec_scan.sv
module ec_scan
    import ec_pkg::*;
#(
    parameter int N_CH     = 10,
    parameter int LEN_W    = 12,
    parameter int ROOM_W   = 12,
    parameter int HDR_WORDS = 28,
    localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int CMP_W   = (LEN_W > ROOM_W) ? LEN_W : ROOM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         ch_avail,
    input  logic [N_CH*LEN_W-1:0]   ch_len,
    input  logic [ROOM_W-1:0]       cf_room,
    output logic                    xfer,
    output logic [CH_W-1:0]         chan,
    output logic [LEN_W-1:0]        widx
);

    typedef struct packed {
        ec_state_e         state;
        logic [CH_W-1:0]   chan;
        logic [LEN_W-1:0]  cnt;
        logic [LEN_W-1:0]  len;
    } scan_t;

    scan_t s_d, s_q;

    logic [LEN_W-1:0] sel_len;
    logic [CMP_W-1:0] room_x, len_x;
    logic             sel_ready, fits;
    logic [CH_W-1:0]  chan_nxt;

    always_comb begin
        sel_len   = ch_len[s_q.chan*LEN_W +: LEN_W];
        sel_ready = ch_avail[s_q.chan];
        room_x    = CMP_W'(cf_room);
        len_x     = CMP_W'(sel_len);
        fits      = room_x >= len_x;
        chan_nxt  = CH_W'(next_chan(int'(s_q.chan), N_CH));

        s_d = s_q;
        case (s_q.state)
            ST_SCAN: begin
                if (!sel_ready) begin
                    s_d.chan = chan_nxt;
                end else if (fits) begin
                    s_d.state = ST_XFER;
                    s_d.cnt   = '0;
                    s_d.len   = sel_len;
                end
            end
            ST_XFER: begin
                if (s_q.cnt == s_q.len - 1'b1) begin
                    s_d.state = ST_SCAN;
                    s_d.chan  = chan_nxt;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.state = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_SCAN, chan: '0, cnt: '0, len: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer = (s_q.state == ST_XFER);
    assign chan = s_q.chan;
    assign widx = s_q.cnt;

    // R2
    chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.chan) < N_CH);

    // R4
    skip_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_SCAN && !ch_avail[s_q.chan])
        |=> (s_q.state == ST_SCAN
             && s_q.chan == CH_W'(next_chan(int'($past(s_q.chan)), N_CH))));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_SCAN && ch_avail[s_q.chan] && !fits)
        |=> (s_q.state == ST_SCAN && $stable(s_q.chan)));

    // R5
    no_interrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_XFER && s_q.cnt != s_q.len - 1'b1)
        |=> (s_q.state == ST_XFER && $stable(s_q.chan)
             && s_q.cnt == $past(s_q.cnt) + 1'b1));

    // R9
    min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.state == ST_XFER) |-> (int'(s_q.len) >= HDR_WORDS));

endmodule

// File: rtl/ec_tag.sv
module ec_tag #(
    parameter int N_CH    = 10,
    parameter int WORD_W  = 16,
    parameter int LEN_W   = 12,
    parameter int TAG_IDX = 1,
    parameter int TAG_LSB = 0,
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xfer,
    input  logic [CH_W-1:0]          chan,
    input  logic [LEN_W-1:0]         widx,
    input  logic [N_CH*WORD_W-1:0]   ch_word,
    output logic [N_CH-1:0]          ch_pop,
    output logic                     cf_wr,
    output logic [WORD_W-1:0]        cf_data,
    output logic [CH_W-1:0]          cf_chan
);

    logic [WORD_W-1:0] raw_word;

    always_comb begin
        raw_word = ch_word[chan*WORD_W +: WORD_W];
        cf_data  = raw_word;
        if (int'(widx) == TAG_IDX) begin
            cf_data[TAG_LSB +: CH_W] = chan;
        end
        cf_wr   = xfer;
        cf_chan = chan;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_pop
        assign ch_pop[c] = xfer && (int'(chan) == c);
    end

    // R5
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_pop));

    // R8
    pop_matches_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_wr |-> ($countones(ch_pop) == 1 && ch_pop[cf_chan]));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cf_wr |-> (ch_pop == '0));

endmodule

// File: rtl/evt_rr_collector.sv
module evt_rr_collector #(
    parameter int N_CH      = 10,
    parameter int WORD_W    = 16,
    parameter int LEN_W     = 12,
    parameter int ROOM_W    = 12,
    parameter int HDR_WORDS = 28,
    parameter int TAG_IDX   = 1,
    parameter int TAG_LSB   = 0,
    localparam int CH_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         ch_avail,
    input  logic [N_CH*LEN_W-1:0]   ch_len,
    input  logic [N_CH*WORD_W-1:0]  ch_word,
    output logic [N_CH-1:0]         ch_pop,
    input  logic [ROOM_W-1:0]       cf_room,
    output logic                    cf_wr,
    output logic [WORD_W-1:0]       cf_data,
    output logic [CH_W-1:0]         cf_chan
);

    logic             xfer;
    logic [CH_W-1:0]  chan;
    logic [LEN_W-1:0] widx;

    ec_scan #(
        .N_CH      (N_CH),
        .LEN_W     (LEN_W),
        .ROOM_W    (ROOM_W),
        .HDR_WORDS (HDR_WORDS)
    ) i_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_avail (ch_avail),
        .ch_len   (ch_len),
        .cf_room  (cf_room),
        .xfer     (xfer),
        .chan     (chan),
        .widx     (widx)
    );

    ec_tag #(
        .N_CH    (N_CH),
        .WORD_W  (WORD_W),
        .LEN_W   (LEN_W),
        .TAG_IDX (TAG_IDX),
        .TAG_LSB (TAG_LSB)
    ) i_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer    (xfer),
        .chan    (chan),
        .widx    (widx),
        .ch_word (ch_word),
        .ch_pop  (ch_pop),
        .cf_wr   (cf_wr),
        .cf_data (cf_data),
        .cf_chan (cf_chan)
    );

    // R6
    room_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cf_wr) |-> (int'(cf_room) >= int'(ch_len[cf_chan*LEN_W +: LEN_W])));

endmodule

// File: tb/test_evt_rr_collector.sv
module test_evt_rr_collector;

    localparam int NC = 10;
    localparam int WW = 16;
    localparam int LW = 12;
    localparam int RW = 12;
    localparam int ME = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     ch_avail;
    logic [NC*LW-1:0]  ch_len;
    logic [NC*WW-1:0]  ch_word;
    logic [NC-1:0]     ch_pop;
    logic [RW-1:0]     cf_room = '1;
    logic              cf_wr;
    logic [WW-1:0]     cf_data;
    logic [3:0]        cf_chan;

    always #2.5 clk = ~clk;

    evt_rr_collector i_evt_rr_collector (
        .clk(clk), .rst_n(rst_n), .ch_avail(ch_avail), .ch_len(ch_len),
        .ch_word(ch_word), .ch_pop(ch_pop), .cf_room(cf_room),
        .cf_wr(cf_wr), .cf_data(cf_data), .cf_chan(cf_chan)
    );

    int ev_len [NC][ME];
    int ev_cnt [NC];
    int head   [NC];
    int idx    [NC];
    int cyc;
    int checks = 0;
    int errors = 0;
    logic [WW-1:0] got_d[$];
    int            got_c[$];
    int            got_t[$];
    logic [WW-1:0] ex_d[$];
    int            ex_c[$];
    bit            ex_f[$];

    function automatic logic [WW-1:0] src_word(int c, int e, int i);
        return WW'(((c * 16 + e) * 256) + (i & 255));
    endfunction

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            ch_avail[c] = head[c] < ev_cnt[c];
            ch_len[c*LW +: LW] = ch_avail[c] ? LW'(ev_len[c][head[c]]) : '0;
            ch_word[c*WW +: WW] = ch_avail[c] ? src_word(c, head[c], idx[c]) : '0;
        end
    end

    initial begin
        logic [NC-1:0] p;
        cyc = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) cyc = 0;
            else cyc++;
            if (rst_n && cf_wr) begin
                got_d.push_back(cf_data);
                got_c.push_back(int'(cf_chan));
                got_t.push_back(cyc);
            end
            p = ch_pop;
            @(posedge clk);
            #1;
            for (int c = 0; c < NC; c++) begin
                if (p[c] && head[c] < ev_cnt[c]) begin
                    idx[c]++;
                    if (idx[c] == ev_len[c][head[c]]) begin
                        head[c]++;
                        idx[c] = 0;
                    end
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cf_room = '1;
        for (int c = 0; c < NC; c++) begin
            ev_cnt[c] = 0; head[c] = 0; idx[c] = 0;
        end
        got_d.delete(); got_c.delete(); got_t.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic release_reset();
        @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    task automatic add_ev(int c, int len);
        ev_len[c][ev_cnt[c]] = len;
        ev_cnt[c]++;
    endtask

    task automatic build_expect();
        int h[NC];
        int left = 0;
        int ptr = 0;
        logic [WW-1:0] w;
        ex_d.delete(); ex_c.delete(); ex_f.delete();
        for (int c = 0; c < NC; c++) begin
            h[c] = 0;
            left += ev_cnt[c];
        end
        while (left > 0) begin
            if (h[ptr] < ev_cnt[ptr]) begin
                for (int i = 0; i < ev_len[ptr][h[ptr]]; i++) begin
                    w = src_word(ptr, h[ptr], i);
                    if (i == 1) w[3:0] = 4'(ptr);
                    ex_d.push_back(w);
                    ex_c.push_back(ptr);
                    ex_f.push_back(i == 0);
                end
                h[ptr]++;
                left--;
            end
            ptr = (ptr == NC - 1) ? 0 : ptr + 1;
        end
    endtask

    task automatic run_until_done(int limit);
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            #1;
            if (got_d.size() >= ex_d.size()) break;
        end
    endtask

    task automatic compare_stream(string req);
        int bad_d = -1;
        int bad_c = -1;
        int bad_t = -1;
        chk(got_d.size() == ex_d.size(), {req, " word count"}, got_d.size(), ex_d.size());
        for (int i = 0; i < ex_d.size() && i < got_d.size(); i++) begin
            if (bad_d < 0 && got_d[i] != ex_d[i]) bad_d = i;
            if (bad_c < 0 && got_c[i] != ex_c[i]) bad_c = i;
            if (bad_t < 0 && i > 0 && !ex_f[i] && got_t[i] != got_t[i-1] + 1) bad_t = i;
        end
        if (bad_d >= 0)
            chk(0, {req, " R7 word content"}, int'(got_d[bad_d]), int'(ex_d[bad_d]));
        else
            chk(1, {req, " R7 word content"}, 0, 0);
        if (bad_c >= 0)
            chk(0, {req, " R8 channel tag"}, got_c[bad_c], ex_c[bad_c]);
        else
            chk(1, {req, " R8 channel tag"}, 0, 0);
        if (bad_t >= 0)
            chk(0, {req, " R5 contiguous words"}, got_t[bad_t], got_t[bad_t-1] + 1);
        else
            chk(1, {req, " R5 contiguous words"}, 0, 0);
    endtask

    task automatic t_reset();
        do_reset();
        add_ev(0, 28);
        @(negedge clk);
        #1;
        chk(cf_wr == 1'b0, "R1 no write in reset", int'(cf_wr), 0);
        chk(ch_pop == '0, "R1 no pop in reset", int'(ch_pop), 0);
        release_reset();
        @(negedge clk);
        #1;
        chk(cf_wr == 1'b0, "R1 first cycle quiet", int'(cf_wr), 0);
        @(negedge clk);
        #1;
        chk(cf_wr == 1'b1 && cf_chan == 4'd0, "R1 scan starts at channel 0",
            int'(cf_chan), 0);
    endtask

    task automatic t_full_lap();
        do_reset();
        for (int c = 0; c < NC; c++) begin
            add_ev(c, 28 + c);
            add_ev(c, 30 + (c % 3));
        end
        build_expect();
        release_reset();
        run_until_done(2000);
        compare_stream("R2 R3 two laps with wrap");
    endtask

    task automatic t_imbalance();
        do_reset();
        add_ev(3, 29); add_ev(3, 33); add_ev(3, 28);
        add_ev(7, 31);
        add_ev(0, 28);
        build_expect();
        release_reset();
        run_until_done(2000);
        compare_stream("R3 busy channel one event per visit");
    endtask

    task automatic t_skip_timing();
        do_reset();
        add_ev(9, 28);
        release_reset();
        run_until_done(200);
        chk(got_t.size() > 0 && got_t[0] == 11, "R4 empty channel skip timing",
            (got_t.size() > 0) ? got_t[0] : -1, 11);
        chk(got_c.size() > 0 && got_c[0] == 9, "R4 channel 9 served",
            (got_c.size() > 0) ? got_c[0] : -1, 9);
    endtask

    task automatic t_stall();
        do_reset();
        add_ev(2, 40);
        add_ev(3, 30);
        cf_room = RW'(35);
        build_expect();
        release_reset();
        repeat (30) @(negedge clk);
        #1;
        chk(got_d.size() == 0, "R6 no write while stalled", got_d.size(), 0);
        chk(ch_pop == '0, "R6 no pop while stalled", int'(ch_pop), 0);
        cf_room = '1;
        run_until_done(500);
        compare_stream("R6 stalled channel served first");
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            ev_cnt[c] = 0; head[c] = 0; idx[c] = 0;
        end
        t_reset();
        t_full_lap();
        t_imbalance();
        t_skip_timing();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule